// File: doc/BRIEF.md
# Raster Line Counter Interrupt Generator

This block keeps track of the current video line inside a 256-line frame. It advances by one line for every pulse on its line-tick enable. From the line number it produces two level signals meant for the edge-sensitive interrupt inputs of a parallel interface adapter:

- **Mid-frame level.** It follows line-address bit 5, so it toggles once every 32 lines. This gives a periodic interrupt, normally wired to the adapter's port-B edge input.
- **End-of-frame level.** It is the AND of the four most significant line-address bits. It is high from line 240 until the counter wraps to line 0, and is normally wired to the adapter's port-A edge input.

A processor can also read a coarse line number over the data bus. The value is quantised to multiples of four lines: the two low bits always read as zero. The count and both levels are registered and change together on the clock edge that advances the line. The read data is decoded combinationally from the registered count, gated by a single chip select.

Top module: `raster_irq_gen`

## Requirements
- R1: With the synchronous reset `rst` high at a rising clock edge, the line count becomes 0 and both `mid_irq_lvl` and `end_irq_lvl` are low after that edge.
- R2: At a rising edge with `line_tick` high, the line count advances by exactly one. With `line_tick` low, the count and both levels hold their values.
- R3: After line 255, the next tick returns the count to line 0, which clears `end_irq_lvl`.
- R4: `mid_irq_lvl` equals bit 5 of the current line number. It is high on lines 32–63, 96–127, 160–191 and 224–255, and low elsewhere.
- R5: `end_irq_lvl` is high exactly on lines 240 through 255. It rises on the same clock edge that moves the count to 240.
- R6: With `rd_cs` high, `rd_data` returns the current line number with bits 1 and 0 forced to zero (line AND 0xFC). It updates in the same cycle as the count, with no added register stage.
- R7: With `rd_cs` low, `rd_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_tick | input | 1 | One-cycle enable that advances the line count |
| rd_cs | input | 1 | Chip select for the line-count read port |
| rd_data | output | 8 | Quantised line number when selected, zero otherwise |
| mid_irq_lvl | output | 1 | Periodic level, line bit 5 |
| end_irq_lvl | output | 1 | High on lines 240 to 255 |

## Verification

The bench walks the count through more than two full frames, with idle cycles mixed in, and compares every visible line against a modelled line number.

The corner cases it targets, and what a faulty design would show:

- **The 255 to 0 wrap.** A counter that saturated or skipped would leave the end level stuck high.
- **The 239/240 boundary.** A decode of the wrong bits, or one delayed by a register, would raise the end level on the wrong line.
- **The 31/32 and 63/64 boundaries.** Tapping the wrong bit would move these toggles.
- **Lines that are not multiples of four.** A missing quantisation mask would leak the low bits onto the bus.

A reset in the middle of a frame, and reads with the chip select low, show whether state or data escapes when it should not.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
   localparam int unsigned LCG_LINE_W  = 8;
   localparam int unsigned LCG_DATA_W  = 8;
   localparam int unsigned LCG_MID_BIT = 5;
   localparam int unsigned LCG_END_TOP = 4;
   localparam int unsigned LCG_QUANT   = 2;

   typedef struct packed {
      logic mid;
      logic fin;
   } lcg_levels_t;
endpackage

// File: rtl/lcg_line_counter.sv
module lcg_line_counter #(
   parameter int unsigned LINE_W = lcg_pkg::LCG_LINE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   output logic [LINE_W-1:0] cnt_q,
   output logic [LINE_W-1:0] cnt_next
);
   localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

   if (LINE_W < 2) begin : g_bad_width
      $error("lcg_line_counter: LINE_W must be at least 2");
   end

   // Next value; it wraps naturally at the power-of-two frame length
   always_comb begin
      if (rst)       cnt_next = '0;
      else if (tick) cnt_next = cnt_q + ONE;
      else           cnt_next = cnt_q;
   end

   always_ff @(posedge clk) begin
      cnt_q <= cnt_next;
   end

   // R2
   step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
      tick |=> (cnt_q == $past(cnt_q) + ONE));

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt_q));

   // R3
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && (&cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/lcg_irq_decode.sv
module lcg_irq_decode #(
   parameter int unsigned LINE_W     = lcg_pkg::LCG_LINE_W,
   parameter int unsigned MID_BIT    = lcg_pkg::LCG_MID_BIT,
   parameter int unsigned END_TOP    = lcg_pkg::LCG_END_TOP,
   parameter bit          REG_LEVELS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LINE_W-1:0] cnt_q,
   input  logic [LINE_W-1:0] cnt_next,
   output lcg_pkg::lcg_levels_t lvl
);
   localparam int unsigned END_LO = LINE_W - END_TOP;

   if (MID_BIT >= LINE_W) begin : g_bad_mid
      $error("lcg_irq_decode: MID_BIT outside the line address");
   end
   if (END_TOP == 0 || END_TOP > LINE_W) begin : g_bad_end
      $error("lcg_irq_decode: END_TOP must be 1..LINE_W");
   end

   if (REG_LEVELS) begin : g_registered
      // Levels are decoded from the next count, so they switch with it
      lcg_pkg::lcg_levels_t lvl_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            lvl_q <= '0;
         end else begin
            lvl_q.mid <= cnt_next[MID_BIT];
            lvl_q.fin <= &cnt_next[LINE_W-1:END_LO];
         end
      end
      assign lvl = lvl_q;
   end else begin : g_decoded
      // cnt_next is only used by the registered variant
      logic unused_next;
      assign unused_next = ^cnt_next;
      assign lvl.mid = cnt_q[MID_BIT];
      assign lvl.fin = &cnt_q[LINE_W-1:END_LO];
   end

   // R4
   mid_follows_bit_chk: assert property (@(posedge clk) disable iff (rst)
      $changed(lvl.mid) |-> (cnt_q[MID_BIT-1:0] == '0));

   // R5
   end_rise_line_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(lvl.fin) |-> (cnt_q[END_LO-1:0] == '0));

   // R3
   end_fall_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(lvl.fin) |-> (cnt_q == '0));
endmodule

// File: rtl/lcg_readback.sv
module lcg_readback #(
   parameter int unsigned LINE_W = lcg_pkg::LCG_LINE_W,
   parameter int unsigned DATA_W = lcg_pkg::LCG_DATA_W,
   parameter int unsigned QUANT  = lcg_pkg::LCG_QUANT
) (
   input  logic              cs,
   input  logic [LINE_W-1:0] cnt_q,
   output logic [DATA_W-1:0] data
);
   localparam logic [LINE_W-1:0] QMASK = ~LINE_W'((1 << QUANT) - 1);

   if (QUANT >= LINE_W) begin : g_bad_quant
      $error("lcg_readback: QUANT must be below LINE_W");
   end

   logic [LINE_W-1:0] coarse;
   assign coarse = cnt_q & QMASK;

   if (DATA_W >= LINE_W) begin : g_wide_bus
      assign data = cs ? DATA_W'(coarse) : '0;
   end else begin : g_narrow_bus
      assign data = cs ? coarse[LINE_W-1 -: DATA_W] : '0;
   end

   // R6
   always_comb begin
      low_bits_zero_chk: assert (data[QUANT-1:0] == '0);
   end

   // R7
   always_comb begin
      idle_bus_chk: assert (cs || data == '0);
   end
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen #(
   parameter int unsigned LINE_W     = lcg_pkg::LCG_LINE_W,
   parameter int unsigned DATA_W     = lcg_pkg::LCG_DATA_W,
   parameter int unsigned MID_BIT    = lcg_pkg::LCG_MID_BIT,
   parameter int unsigned END_TOP    = lcg_pkg::LCG_END_TOP,
   parameter int unsigned QUANT      = lcg_pkg::LCG_QUANT,
   parameter bit          REG_LEVELS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              line_tick,
   input  logic              rd_cs,
   output logic [DATA_W-1:0] rd_data,
   output logic              mid_irq_lvl,
   output logic              end_irq_lvl
);
   logic [LINE_W-1:0]    cnt_q;
   logic [LINE_W-1:0]    cnt_next;
   lcg_pkg::lcg_levels_t lvl;

   lcg_line_counter #(.LINE_W(LINE_W)) u_count (
      .clk      (clk),
      .rst      (rst),
      .tick     (line_tick),
      .cnt_q    (cnt_q),
      .cnt_next (cnt_next)
   );

   lcg_irq_decode #(
      .LINE_W     (LINE_W),
      .MID_BIT    (MID_BIT),
      .END_TOP    (END_TOP),
      .REG_LEVELS (REG_LEVELS)
   ) u_irq (
      .clk      (clk),
      .rst      (rst),
      .cnt_q    (cnt_q),
      .cnt_next (cnt_next),
      .lvl      (lvl)
   );

   lcg_readback #(
      .LINE_W (LINE_W),
      .DATA_W (DATA_W),
      .QUANT  (QUANT)
   ) u_rd (
      .cs    (rd_cs),
      .cnt_q (cnt_q),
      .data  (rd_data)
   );

   assign mid_irq_lvl = lvl.mid;
   assign end_irq_lvl = lvl.fin;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (cnt_q == '0 && !mid_irq_lvl && !end_irq_lvl));
endmodule

// File: tb/raster_irq_gen_test.sv
module raster_irq_gen_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       line_tick = 1'b0;
   logic       rd_cs = 1'b1;
   logic [7:0] rd_data;
   logic       mid_irq_lvl;
   logic       end_irq_lvl;

   int errors = 0;
   int checks = 0;
   int line_m = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   raster_irq_gen uut (
      .clk         (clk),
      .rst         (rst),
      .line_tick   (line_tick),
      .rd_cs       (rd_cs),
      .rd_data     (rd_data),
      .mid_irq_lvl (mid_irq_lvl),
      .end_irq_lvl (end_irq_lvl)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s line=%0d actual=%0d expected=%0d", req, line_m, act, exp);
      end
   endtask

   // Compare all outputs against the modelled line (called mid-cycle)
   task automatic check_line(input string tag);
      rd_cs = 1'b1;
      #1;
      chk({tag, " R6 rd_data"}, int'(rd_data), line_m & 8'hFC);
      chk({tag, " R4 mid"}, int'(mid_irq_lvl), (line_m >> 5) & 1);
      chk({tag, " R5 end"}, int'(end_irq_lvl), (line_m >= 240) ? 1 : 0);
   endtask

   // Advance one clock with the given tick and check afterwards
   task automatic step(input bit t, input string tag);
      @(negedge clk);
      line_tick = t;
      @(negedge clk);
      line_tick = 1'b0;
      if (t) line_m = (line_m + 1) % 256;
      check_line(tag);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      line_m = 0;
      check_line("R1 reset");
      // R7: deselected bus reads zero
      rd_cs = 1'b0; #1;
      chk("R7 deselected", int'(rd_data), 0);
      rd_cs = 1'b1;
      // R2/R3/R4/R5/R6: sweep more than two frames with idle gaps
      for (int i = 0; i < 600; i++) begin
         step(1'b1, "R2 sweep");
         if (i % 7 == 3) step(1'b0, "R2 idle");
         if (i % 53 == 10) begin
            rd_cs = 1'b0; #1;
            chk("R7 deselected", int'(rd_data), 0);
            rd_cs = 1'b1;
         end
         if (line_m == 0) chk("R3 wrap end low", int'(end_irq_lvl), 0);
      end
      // R1: reset in mid frame, with a tick asserted at the same edge
      while (line_m != 250) step(1'b1, "R2 pre-reset");
      @(negedge clk);
      rst = 1'b1;
      line_tick = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      line_tick = 1'b0;
      line_m = 0;
      check_line("R1 mid-frame reset");
      for (int i = 0; i < 5; i++) step(1'b0, "R2 hold after reset");
      for (int i = 0; i < 70; i++) step(1'b1, "R4 post-reset");
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule